// File: doc/BRIEF.md
# Edge-Width Preamble and Sync Detector

This block listens to an asynchronous serial receive line and decides when a burst of alternating-bit training pattern has been seen and, after it, when the start of a sync byte arrives. It never samples bits. Instead, it measures the number of clocks between consecutive transitions of either polarity. It then compares that width against tolerance windows centred on whole multiples of the bit period.

In the calibrating state, widths of one or two bit periods raise a saturating credit count, and any other width lowers it. Once the credit reaches a target, the block fires a one-cycle lock pulse and holds a lock level for an external data-slicer averaging filter. It then moves to sync search. Sync search discards a fixed number of early edges as noise. After that, a single edge whose width equals five bit periods marks the sync byte: the idle-high stop bit, the low start bit and the low first nibble of a byte sent low-bit first. On that edge the block raises its receive-enable output for a downstream UART and stops measuring.

A session-start strobe restarts the search from the calibrating state. If the skip-calibration input is high during the strobe, the block goes straight to sync search.

Top module: `edge_sync_detector`

## Requirements
- R1: The line passes through a two-flop synchronizer, and a transition of either polarity counts as an edge. The width of an edge is the number of clock cycles since the previous edge, or since reset, session start or sync if no edge has occurred since then.
- R2: A width w counts as N bit periods only when 0.9·N·CLKS_PER_BIT < w < 1.1·N·CLKS_PER_BIT, with both bounds excluded. With CLKS_PER_BIT=20, the one-bit window is 19..21, the two-bit window is 37..43 and the five-bit window is 91..109.
- R3: While calibrating, an edge whose width is one or two bit periods increments the credit count. Any other width decrements it, and it never goes below zero.
- R4: The edge that brings the credit count to PREAMBLE_GOAL (40) raises `lock_pulse` for exactly one cycle, sets `lock_hold` and enters sync search.
- R5: In sync search, the first SKIP_EDGES (20) edges are not evaluated, whatever their width.
- R6: After those edges, the first edge whose width is SYNC_BITS (5) bit periods sets `rx_enable`. From then on, edges are ignored and `rx_enable` stays high until the next session start.
- R7: A session start with `skip_cal` low clears `lock_hold`, `rx_enable`, the credit count, the edge count and the width reference, and returns to calibrating.
- R8: A session start with `skip_cal` high enters sync search directly. It produces no lock pulse, leaves `lock_hold` unchanged and clears `rx_enable`.
- R9: The width counter saturates at its all-ones value, so a long quiet line can never alias into an accepted window.
- R10: After reset, `lock_pulse`, `lock_hold` and `rx_enable` are low and the block is calibrating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial receive line, idle high |
| session_start | input | 1 | One-cycle strobe that restarts detection |
| skip_cal | input | 1 | Sampled with `session_start`: high enters sync search directly |
| lock_pulse | output | 1 | One-cycle pulse when the preamble credit reaches its goal |
| lock_hold | output | 1 | Level: the slicer filter should stay locked |
| rx_enable | output | 1 | Level: sync found, UART reception enabled |

## Verification
The bench builds the block with CLKS_PER_BIT=20 and keeps the defaults of 40 credits, 20 skipped edges and a five-bit sync width. At this bit period every window edge sits a single clock away from a rejected width, so the bench drives 18, 19, 21, 22, 36, 37, 43 and 44 directly. The same value shrinks the width counter to eight bits. A quiet run of 356 clocks would then wrap to 100, which falls in the sync window, so the test shows whether the counter saturates or wraps. The short bit period also keeps the sequences that exercise the credit decay, the skipped edges and the three session-start paths to a few thousand cycles.

// File: rtl/edge_sync_detector.sv
module edge_sync_detector #(
  parameter int CLKS_PER_BIT  = 320,
  parameter int PREAMBLE_GOAL = 40,
  parameter int SKIP_EDGES    = 20,
  parameter int SYNC_BITS     = 5,
  parameter int TOL_TENTHS    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic session_start,
  input  logic skip_cal,
  output logic lock_pulse,
  output logic lock_hold,
  output logic rx_enable
);
  localparam int CNT_W = $clog2(2 * SYNC_BITS * CLKS_PER_BIT + 1);
  localparam int MW    = CNT_W + 5;
  localparam int PC_W  = $clog2(PREAMBLE_GOAL + 1);
  localparam int EC_W  = $clog2(SKIP_EDGES + 1);
  localparam logic [CNT_W-1:0] WMAX = '1;

  typedef enum logic [1:0] {ST_CAL, ST_SRCH, ST_DONE} st_t;

  st_t              state;
  logic [2:0]       rx_sh;
  logic [CNT_W-1:0] wcnt;
  logic [PC_W-1:0]  pcnt;
  logic [EC_W-1:0]  ecnt;

  function automatic logic in_win(input logic [MW-1:0] v, input int nb);
    return (v > MW'((10 - TOL_TENTHS) * nb * CLKS_PER_BIT)) &&
           (v < MW'((10 + TOL_TENTHS) * nb * CLKS_PER_BIT));
  endfunction

  wire             edge_seen = rx_sh[2] ^ rx_sh[1];
  wire [MW-1:0]    w10       = (MW'(wcnt) << 3) + (MW'(wcnt) << 1);
  wire             short_ok  = in_win(w10, 1) || in_win(w10, 2);
  wire             sync_ok   = in_win(w10, SYNC_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh      <= 3'b111;
      state      <= ST_CAL;
      wcnt       <= '0;
      pcnt       <= '0;
      ecnt       <= '0;
      lock_pulse <= 1'b0;
      lock_hold  <= 1'b0;
      rx_enable  <= 1'b0;
    end else begin
      rx_sh      <= {rx_sh[1:0], rx_line};
      lock_pulse <= 1'b0;
      if (session_start) begin
        state     <= skip_cal ? ST_SRCH : ST_CAL;
        if (!skip_cal) lock_hold <= 1'b0;
        rx_enable <= 1'b0;
        pcnt      <= '0;
        ecnt      <= '0;
        wcnt      <= '0;
      end else begin
        if (state == ST_DONE)    wcnt <= '0;
        else if (edge_seen)      wcnt <= CNT_W'(1);
        else if (wcnt != WMAX)   wcnt <= wcnt + 1'b1;
        case (state)
          ST_CAL: if (edge_seen) begin
            if (short_ok) begin
              if (pcnt == PC_W'(PREAMBLE_GOAL - 1)) begin
                lock_pulse <= 1'b1;
                lock_hold  <= 1'b1;
                state      <= ST_SRCH;
                pcnt       <= '0;
                ecnt       <= '0;
              end else begin
                pcnt <= pcnt + 1'b1;
              end
            end else if (pcnt != '0) begin
              pcnt <= pcnt - 1'b1;
            end
          end
          ST_SRCH: if (edge_seen) begin
            if (ecnt < EC_W'(SKIP_EDGES)) begin
              ecnt <= ecnt + 1'b1;
            end else if (sync_ok) begin
              rx_enable <= 1'b1;
              state     <= ST_DONE;
              ecnt      <= '0;
              pcnt      <= '0;
              wcnt      <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/edge_sync_detector_chk.sv
module edge_sync_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic session_start,
  input logic skip_cal,
  input logic lock_pulse,
  input logic lock_hold,
  input logic rx_enable
);
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse |=> !lock_pulse);
  assert_pulse_sets_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse |-> lock_hold);
  assert_rxen_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && !session_start) |=> rx_enable);
  assert_no_pulse_after_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_pulse && rx_enable));
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (session_start && !skip_cal) |=> (!lock_hold && !rx_enable && !lock_pulse));
  assert_skip_keeps_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (session_start && skip_cal) |=> (!lock_pulse && !rx_enable && lock_hold == $past(lock_hold)));
endmodule

bind edge_sync_detector edge_sync_detector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .session_start(session_start), .skip_cal(skip_cal),
  .lock_pulse(lock_pulse), .lock_hold(lock_hold), .rx_enable(rx_enable)
);

// File: tb/sim_edge_sync_detector.sv
`timescale 1ns/1ps
module sim_edge_sync_detector;
  localparam int B = 20;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, ss = 1'b0, sk = 1'b0;
  wire  lp, lh, re;

  edge_sync_detector #(.CLKS_PER_BIT(B)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx), .session_start(ss), .skip_cal(sk),
    .lock_pulse(lp), .lock_hold(lh), .rx_enable(re)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    due;
    bit    hold;
    bit    rxe;
    int    pulses;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int cyc = 0, checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_now(bit h, bit r, int p, string tag);
    exp_t e;
    e.due = cyc; e.hold = h; e.rxe = r; e.pulses = p; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && lp) pulses = pulses + 1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      mon_e = q.pop_front();
      checks = checks + 1;
      if (lh !== mon_e.hold || re !== mon_e.rxe || pulses != mon_e.pulses) begin
        errors = errors + 1;
        $display("FAIL %s: hold=%0b rx_en=%0b pulses=%0d, expected hold=%0b rx_en=%0b pulses=%0d",
                 mon_e.tag, lh, re, pulses, mon_e.hold, mon_e.rxe, mon_e.pulses);
      end
    end
  end

  task automatic toggle(int w);
    rx = ~rx;
    repeat (w) @(negedge clk);
  endtask

  task automatic start_session(bit skip);
    ss = 1'b1; sk = skip;
    @(negedge clk);
    ss = 1'b0; sk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors = errors + 1;
      $display("FAIL R6 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_now(0, 0, 0, "R10 reset state");
    repeat (298) @(negedge clk);

    // Widths noted are those measured at each toggle (hold of previous toggle).
    toggle(18);  // saturated width since reset: bad (R9), credit 0
    toggle(22);  // 18 bad
    toggle(44);  // 22 bad
    toggle(36);  // 44 bad
    toggle(19);  // 36 bad -> credit still 0 (R3 floor)
    expect_now(0, 0, 0, "R2 boundary widths rejected");
    toggle(21);  // 19 good ->1
    toggle(37);  // 21 good ->2
    toggle(43);  // 37 good ->3
    toggle(20);  // 43 good ->4
    for (int i = 0; i < 34; i++) toggle(20);  // ->38
    toggle(30);  // 20 good ->39
    expect_now(0, 0, 0, "R3 credit 39 no lock");
    toggle(20);  // 30 bad ->38
    expect_now(0, 0, 0, "R3 decrement on bad width");
    toggle(20);  // ->39
    expect_now(0, 0, 0, "R3 credit back to 39");
    toggle(20);  // ->40 lock
    expect_now(1, 0, 1, "R4 lock at goal, R2 inner bounds accepted");

    toggle(100); // s1 ignored
    toggle(20);  // s2 width 100 ignored
    expect_now(1, 0, 1, "R5 sync-width edge ignored early");
    for (int i = 0; i < 18; i++) toggle(20);  // s3..s20
    toggle(356); // s21 width 20
    toggle(100); // s22 width saturated, would wrap to 100
    expect_now(1, 0, 1, "R9 saturated width not sync");
    toggle(50);  // s23 width 100 -> sync
    expect_now(1, 1, 1, "R6 sync detected, R1 edges counted");
    toggle(100);
    toggle(20);  // width 100 after sync: ignored
    expect_now(1, 1, 1, "R6 edges ignored after sync");

    start_session(1'b0);
    expect_now(0, 0, 1, "R7 session start clears");
    repeat (58) @(negedge clk);
    for (int i = 0; i < 40; i++) toggle(20);  // first bad, then 39 good
    expect_now(0, 0, 1, "R7 credit restarted from zero");
    toggle(20);
    expect_now(1, 0, 2, "R7 relock after restart");

    start_session(1'b1);
    expect_now(1, 0, 2, "R8 skip keeps hold, no pulse");
    repeat (58) @(negedge clk);
    for (int i = 0; i < 19; i++) toggle(20);  // edges 1..19
    toggle(100); // edge 20 width 20
    expect_now(1, 0, 2, "R8 search active, 20 edges skipped");
    toggle(30);  // edge 21 width 100
    expect_now(1, 1, 2, "R8 sync found without calibration");

    start_session(1'b0);
    expect_now(0, 0, 2, "R7 unlock after sync");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule